// File: doc/BRIEF.md
# Split-Tag Address Translation Buffer

This block turns virtual addresses into physical addresses for a core's three kinds of memory access: instruction fetch, data load and data store. It is a direct-mapped buffer of recent translations. The buffer has three separate tag arrays, one per access kind, and a single shared array of physical page numbers. A translation installed for one access kind gives a hit only to requests of that kind, so each tag array works as a per-permission-class record of which translations have already been checked. Pages are 8 KiB. The entry index is taken from the virtual address bits directly above the page offset.

The lookup is combinational. In the same cycle as the request, the block reports one of three results: a hit with the physical address, a refill request carrying the address and the access flags, or a misalignment trap. An external walker answers a refill request by writing an entry through the fill port. A flush input empties the buffer. The block also holds the page-table base register, and any write to that register empties the buffer as well. Data accesses are checked for natural alignment. A misaligned access is not translated, and its virtual address is latched in a bad-address register.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, no request hits, `ptb_q` reads 0 and `badva_q` reads 0.
- R2: After a fill, a request of the same access kind whose full virtual page number matches the filled one gives `rsp_hit`=1. Its `rsp_pa` is the filled physical page number concatenated with the request's 13-bit page offset (address bits [12:0]).
- R3: The access kind is fetch when `req_fetch`=1 (whatever `req_store` is), store when only `req_store`=1, and load otherwise. A fill of one kind gives no hit to requests of the other two kinds. All kinds share one physical page number per index, so a fill of any kind replaces the page number that every kind sees at that index.
- R4: The index is virtual address bits [PG_SHIFT+IDX_W-1:PG_SHIFT]. A hit needs the whole stored virtual page number to equal the request's. Two pages that share an index but differ in higher bits miss each other, and the later fill replaces the earlier one for that kind.
- R5: A valid, non-trapping request that misses asserts `refill_req` in the same cycle, with `refill_va`, `refill_store` and `refill_fetch` copying the request. `rsp_hit` and `refill_req` are never both 1.
- R6: A flush pulse invalidates every entry of all three kinds from the next cycle on.
- R7: A page-table base write stores the write data with bits [12:0] cleared into `ptb_q` and invalidates every entry from the next cycle on.
- R8: When a fill and a flush (or a base-register write) occur in the same cycle, the flush wins and the fill leaves no valid entry.
- R9: `req_size` encodes the access width as 0=1, 1=2, 2=4 and 3=8 bytes. A load or store whose address is not a multiple of that width raises `trap_ld` or `trap_st` respectively. It gives neither a hit nor a refill request, and its virtual address appears in `badva_q` from the next cycle on.
- R10: Fetch requests are never checked for alignment and never raise a trap.
- R11: With `req_valid`=0 there is no hit, refill request or trap, and `badva_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | VA_W | Request virtual address |
| req_store | input | 1 | Request is a store |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_size | input | 2 | Access width code for the alignment check |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | PA_W | Physical address, meaningful on a hit |
| refill_req | output | 1 | Miss; asks the walker for an entry |
| refill_va | output | VA_W | Address to be walked |
| refill_store | output | 1 | Store flag of the missing request |
| refill_fetch | output | 1 | Fetch flag of the missing request |
| trap_ld | output | 1 | Misaligned load |
| trap_st | output | 1 | Misaligned store |
| badva_q | output | VA_W | Last misaligned virtual address |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | VA_W-PG_SHIFT | Virtual page number of the entry |
| fill_store | input | 1 | Entry kind: store |
| fill_fetch | input | 1 | Entry kind: fetch (takes priority) |
| fill_ppn | input | PA_W-PG_SHIFT | Physical page number of the entry |
| flush | input | 1 | Invalidate all entries |
| ptb_we | input | 1 | Page-table base write |
| ptb_wdata | input | PA_W | Page-table base write data |
| ptb_q | output | PA_W | Page-table base register |

## Verification
The bench builds the block with 32-bit virtual and physical addresses and a 16-entry index (IDX_W=4). With only 16 entries, random addresses drawn from two upper-address patterns collide often. That puts same-index replacement, cross-kind overwrites of the shared page number and tag mismatches in the higher bits within easy reach. Page offsets and access widths are drawn at random, so both aligned and misaligned cases come up for every width code. Fills, flushes and base-register writes are mixed into the same cycles so that the flush-priority case also arises.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2
    } acc_kind_e;

    localparam int NUM_KINDS = 3;

    typedef struct packed {
        logic trap_ld;
        logic trap_st;
    } align_res_t;

    function automatic acc_kind_e kind_of(input logic is_store, input logic is_fetch);
        if (is_fetch)      return KIND_FETCH;
        else if (is_store) return KIND_STORE;
        else               return KIND_LOAD;
    endfunction

    function automatic logic is_misaligned(input logic [2:0] low, input logic [1:0] size);
        case (size)
            2'd0:    return 1'b0;
            2'd1:    return low[0];
            2'd2:    return |low[1:0];
            default: return |low;
        endcase
    endfunction

endpackage

// File: rtl/tlb_tag_bank.sv
module tlb_tag_bank #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 51
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             match
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign match = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
endmodule

// File: rtl/tlb_data_bank.sv
module tlb_data_bank #(
    parameter int IDX_W = 8,
    parameter int PPN_W = 51
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [PPN_W-1:0] ppn_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ppn_mem[wr_idx] <= wr_ppn;
        end
    end

    assign rd_ppn = ppn_mem[rd_idx];
endmodule

// File: rtl/tlb_align_chk.sv
module tlb_align_chk
    import tlb_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_store,
    input  logic       req_fetch,
    input  logic [1:0] req_size,
    input  logic [2:0] va_low,
    output align_res_t res
);
    logic bad;

    always_comb begin
        bad         = req_valid && !req_fetch && is_misaligned(va_low, req_size);
        res.trap_st = bad && req_store;
        res.trap_ld = bad && !req_store;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PA_W     = 64,
    parameter int PG_SHIFT = 13,
    parameter int IDX_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_va,
    input  logic                   req_store,
    input  logic                   req_fetch,
    input  logic [1:0]             req_size,
    output logic                   rsp_hit,
    output logic [PA_W-1:0]        rsp_pa,
    output logic                   refill_req,
    output logic [VA_W-1:0]        refill_va,
    output logic                   refill_store,
    output logic                   refill_fetch,
    output logic                   trap_ld,
    output logic                   trap_st,
    output logic [VA_W-1:0]        badva_q,
    input  logic                   fill_en,
    input  logic [VA_W-PG_SHIFT-1:0] fill_vpn,
    input  logic                   fill_store,
    input  logic                   fill_fetch,
    input  logic [PA_W-PG_SHIFT-1:0] fill_ppn,
    input  logic                   flush,
    input  logic                   ptb_we,
    input  logic [PA_W-1:0]        ptb_wdata,
    output logic [PA_W-1:0]        ptb_q
);
    localparam int TAG_W = VA_W - PG_SHIFT;
    localparam int PPN_W = PA_W - PG_SHIFT;
    localparam logic [PA_W-1:0] PG_KEEP = ~((PA_W'(1) << PG_SHIFT) - PA_W'(1));

    logic                 clr_all;
    acc_kind_e            req_kind;
    acc_kind_e            fill_kind;
    logic [TAG_W-1:0]     req_vpn;
    logic [IDX_W-1:0]     req_idx;
    logic [IDX_W-1:0]     fill_idx;
    logic [NUM_KINDS-1:0] kind_match;
    logic [PPN_W-1:0]     rd_ppn;
    align_res_t           align;
    logic                 trapped;
    logic                 lookup;

    assign clr_all   = flush || ptb_we;
    assign req_kind  = kind_of(req_store, req_fetch);
    assign fill_kind = kind_of(fill_store, fill_fetch);
    assign req_vpn   = req_va[VA_W-1:PG_SHIFT];
    assign req_idx   = req_vpn[IDX_W-1:0];
    assign fill_idx  = fill_vpn[IDX_W-1:0];

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_tags
        tlb_tag_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr_all),
            .wr_en  (fill_en && !clr_all && (fill_kind == acc_kind_e'(k))),
            .wr_idx (fill_idx),
            .wr_tag (fill_vpn),
            .rd_idx (req_idx),
            .rd_tag (req_vpn),
            .match  (kind_match[k])
        );
    end

    tlb_data_bank #(.IDX_W(IDX_W), .PPN_W(PPN_W)) u_data (
        .clk    (clk),
        .wr_en  (fill_en && !clr_all),
        .wr_idx (fill_idx),
        .wr_ppn (fill_ppn),
        .rd_idx (req_idx),
        .rd_ppn (rd_ppn)
    );

    tlb_align_chk u_align (
        .req_valid (req_valid),
        .req_store (req_store),
        .req_fetch (req_fetch),
        .req_size  (req_size),
        .va_low    (req_va[2:0]),
        .res       (align)
    );

    assign trap_ld = align.trap_ld;
    assign trap_st = align.trap_st;
    assign trapped = align.trap_ld || align.trap_st;
    assign lookup  = req_valid && !trapped;

    assign rsp_hit      = lookup && kind_match[req_kind];
    assign rsp_pa       = {rd_ppn, req_va[PG_SHIFT-1:0]};
    assign refill_req   = lookup && !kind_match[req_kind];
    assign refill_va    = req_va;
    assign refill_store = req_store;
    assign refill_fetch = req_fetch;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptb_q   <= '0;
            badva_q <= '0;
        end else begin
            if (ptb_we) begin
                ptb_q <= ptb_wdata & PG_KEEP;
            end
            if (trapped) begin
                badva_q <= req_va;
            end
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VA_W     = 64,
    parameter int PA_W     = 64,
    parameter int PG_SHIFT = 13
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_fetch,
    input logic [VA_W-1:0] req_va,
    input logic            flush,
    input logic            ptb_we,
    input logic            rsp_hit,
    input logic            refill_req,
    input logic            trap_ld,
    input logic            trap_st,
    input logic [VA_W-1:0] badva_q,
    input logic [PA_W-1:0] ptb_q
);
    a_r5_hit_miss_excl: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && refill_req));

    a_r9_trap_no_lookup: assert property (@(posedge clk) disable iff (rst)
        (trap_ld || trap_st) |-> (!rsp_hit && !refill_req));

    a_r9_one_trap: assert property (@(posedge clk) disable iff (rst)
        !(trap_ld && trap_st));

    a_r9_badva_capture: assert property (@(posedge clk) disable iff (rst)
        (trap_ld || trap_st) |=> (badva_q == $past(req_va)));

    a_r10_fetch_no_trap: assert property (@(posedge clk) disable iff (rst)
        req_fetch |-> (!trap_ld && !trap_st));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!rsp_hit && !refill_req && !trap_ld && !trap_st));

    a_r11_badva_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(badva_q));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (flush || ptb_we) |=> !rsp_hit);

    a_r7_ptb_page_aligned: assert property (@(posedge clk) disable iff (rst)
        ptb_q[PG_SHIFT-1:0] == '0);
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_fetch  (req_fetch),
    .req_va     (req_va),
    .flush      (flush),
    .ptb_we     (ptb_we),
    .rsp_hit    (rsp_hit),
    .refill_req (refill_req),
    .trap_ld    (trap_ld),
    .trap_st    (trap_st),
    .badva_q    (badva_q),
    .ptb_q      (ptb_q)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
    localparam int VA_W = 32;
    localparam int PA_W = 32;
    localparam int PGS  = 13;
    localparam int IW   = 4;
    localparam int NE   = 1 << IW;
    localparam int TW   = VA_W - PGS;
    localparam int PW   = PA_W - PGS;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_store, req_fetch;
    logic [VA_W-1:0] req_va;
    logic [1:0] req_size;
    logic rsp_hit, refill_req, refill_store, refill_fetch, trap_ld, trap_st;
    logic [PA_W-1:0] rsp_pa, ptb_q, ptb_wdata;
    logic [VA_W-1:0] refill_va, badva_q;
    logic fill_en, fill_store, fill_fetch, flush, ptb_we;
    logic [TW-1:0] fill_vpn;
    logic [PW-1:0] fill_ppn;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    bit           m_valid [3][NE];
    logic [TW-1:0] m_tag  [3][NE];
    logic [PW-1:0] m_ppn  [NE];
    logic [PA_W-1:0] m_ptb;
    logic [VA_W-1:0] m_badva;

    always #2 clk = ~clk;

    tlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PGS), .IDX_W(IW)) i_tlb_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_store(req_store), .req_fetch(req_fetch), .req_size(req_size),
        .rsp_hit(rsp_hit), .rsp_pa(rsp_pa), .refill_req(refill_req),
        .refill_va(refill_va), .refill_store(refill_store), .refill_fetch(refill_fetch),
        .trap_ld(trap_ld), .trap_st(trap_st), .badva_q(badva_q),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_store(fill_store),
        .fill_fetch(fill_fetch), .fill_ppn(fill_ppn), .flush(flush),
        .ptb_we(ptb_we), .ptb_wdata(ptb_wdata), .ptb_q(ptb_q)
    );

    function automatic int kind(input logic st, input logic fe);
        return fe ? 2 : (st ? 1 : 0);
    endfunction

    function automatic bit misal(input logic [VA_W-1:0] va, input logic [1:0] sz);
        logic [VA_W-1:0] m;
        m = (VA_W'(1) << sz) - VA_W'(1);
        return (va & m) != 0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_va = '0; req_store = 0; req_fetch = 0; req_size = 0;
        fill_en = 0; fill_vpn = '0; fill_store = 0; fill_fetch = 0; fill_ppn = '0;
        flush = 0; ptb_we = 0; ptb_wdata = '0;
    endtask

    // check combinational outputs against the model, then clock and update model
    task automatic cycle(input string req);
        bit tr, h;
        int k;
        logic [IW-1:0] ix;
        #1;
        k  = kind(req_store, req_fetch);
        ix = req_va[PGS +: IW];
        tr = req_valid && !req_fetch && misal(req_va, req_size);
        h  = req_valid && !tr && m_valid[k][ix] && (m_tag[k][ix] == req_va[VA_W-1:PGS]);
        chk(req, "trap_ld", 64'(trap_ld), 64'(tr && !req_store));
        chk(req, "trap_st", 64'(trap_st), 64'(tr && req_store));
        chk(req, "hit", 64'(rsp_hit), 64'(h));
        chk(req, "refill_req", 64'(refill_req), 64'(req_valid && !tr && !h));
        if (h) chk(req, "pa", 64'(rsp_pa), 64'({m_ppn[ix], req_va[PGS-1:0]}));
        if (refill_req) begin
            chk(req, "refill_va", 64'(refill_va), 64'(req_va));
            chk(req, "refill_flags", 64'({refill_store, refill_fetch}), 64'({req_store, req_fetch}));
        end
        chk(req, "ptb_q", 64'(ptb_q), 64'(m_ptb));
        chk(req, "badva_q", 64'(badva_q), 64'(m_badva));
        @(posedge clk);
        if (flush || ptb_we) begin
            for (int a = 0; a < 3; a++) for (int b = 0; b < NE; b++) m_valid[a][b] = 0;
        end else if (fill_en) begin
            m_valid[kind(fill_store, fill_fetch)][fill_vpn[IW-1:0]] = 1;
            m_tag[kind(fill_store, fill_fetch)][fill_vpn[IW-1:0]]   = fill_vpn;
            m_ppn[fill_vpn[IW-1:0]] = fill_ppn;
        end
        if (ptb_we) m_ptb = ptb_wdata & ~PA_W'(32'h1FFF);
        if (tr) m_badva = req_va;
        #1;
        idle();
    endtask

    task automatic do_fill(input logic [VA_W-1:0] va, input logic st, input logic fe,
                           input logic [PW-1:0] ppn, input string req);
        fill_en = 1; fill_vpn = va[VA_W-1:PGS]; fill_store = st; fill_fetch = fe; fill_ppn = ppn;
        cycle(req);
    endtask

    task automatic do_req(input logic [VA_W-1:0] va, input logic st, input logic fe,
                          input logic [1:0] sz, input string req);
        req_valid = 1; req_va = va; req_store = st; req_fetch = fe; req_size = sz;
        cycle(req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        idle();
        rst = 1;
        for (int a = 0; a < 3; a++) for (int b = 0; b < NE; b++) m_valid[a][b] = 0;
        for (int b = 0; b < NE; b++) m_ppn[b] = '0;
        m_ptb = '0; m_badva = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state, a lookup misses
        do_req(32'h0000_6000, 0, 0, 2'd2, "R1");
        // R2: fill load entry then hit with offset
        do_fill(32'h0004_6000, 0, 0, 19'h5A5A5, "R2");
        do_req(32'h0004_7ABC, 0, 0, 2'd2, "R2");
        // R3: same page as store and fetch must miss
        do_req(32'h0004_6010, 1, 0, 2'd3, "R3");
        do_req(32'h0004_6010, 0, 1, 2'd0, "R3");
        // R3: fetch flag wins over store flag
        do_fill(32'h0004_6000, 1, 1, 19'h11111, "R3");
        do_req(32'h0004_6004, 1, 1, 2'd0, "R3");
        do_req(32'h0004_6004, 1, 0, 2'd0, "R3");
        do_req(32'h0004_6008, 0, 0, 2'd3, "R3");  // shared page number now replaced
        // R4: same index, different upper bits
        do_req(32'h8004_6000, 0, 0, 2'd0, "R4");
        do_fill(32'h8004_6000, 0, 0, 19'h22222, "R4");
        do_req(32'h0004_6000, 0, 0, 2'd0, "R4");
        do_req(32'h8004_6000, 0, 0, 2'd0, "R4");
        // R5: miss fields
        do_req(32'h1234_A5A0, 1, 0, 2'd3, "R5");
        // R6: flush
        do_fill(32'h0000_2000, 1, 0, 19'h33333, "R6");
        do_req(32'h0000_2000, 1, 0, 2'd0, "R6");
        flush = 1; cycle("R6");
        do_req(32'h0000_2000, 1, 0, 2'd0, "R6");
        // R7: base write clears low bits and invalidates
        do_fill(32'h0000_2000, 0, 0, 19'h44444, "R7");
        ptb_we = 1; ptb_wdata = 32'h1234_5FFF; cycle("R7");
        do_req(32'h0000_2000, 0, 0, 2'd0, "R7");
        // R8: flush wins over simultaneous fill
        fill_en = 1; fill_vpn = 19'h00003; fill_ppn = 19'h55555; flush = 1; cycle("R8");
        do_req(32'h0000_6000, 0, 0, 2'd0, "R8");
        // R9: misaligned load and store, badva captured
        do_req(32'h0000_6002, 0, 0, 2'd2, "R9");
        do_req(32'h0000_6004, 1, 0, 2'd3, "R9");
        do_req(32'h0000_6001, 1, 0, 2'd1, "R9");
        // R10: fetch with odd address never traps
        do_req(32'h0000_6003, 0, 1, 2'd3, "R10");
        // R11: idle, nothing changes
        cycle("R11");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [VA_W-1:0] va;
            logic [1:0] sz;
            int r;
            sz = 2'($urandom_range(0, 3));
            va = {($urandom_range(0, 1) != 0) ? 15'h0001 : 15'h4000,
                  4'($urandom_range(0, NE - 1)), 13'($urandom)};
            if ($urandom_range(0, 9) < 8) va = va & ~((VA_W'(1) << sz) - VA_W'(1));
            r = $urandom_range(0, 99);
            req_valid = (r < 85); req_va = va; req_size = sz;
            req_store = $urandom_range(0, 1) != 0; req_fetch = $urandom_range(0, 3) == 0;
            if ($urandom_range(0, 3) == 0) begin
                fill_en = 1;
                fill_vpn = {($urandom_range(0, 1) != 0) ? 15'h0001 : 15'h4000,
                            4'($urandom_range(0, NE - 1))};
                fill_store = $urandom_range(0, 1) != 0;
                fill_fetch = $urandom_range(0, 2) == 0;
                fill_ppn = 19'($urandom);
            end
            flush = ($urandom_range(0, 99) == 0);
            if ($urandom_range(0, 149) == 0) begin ptb_we = 1; ptb_wdata = $urandom; end
            cycle("R2-mix");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule